// File: doc/BRIEF.md
# Dual-Path SPI Bit-Clock Divider

This block turns a fast source clock into the serial clock of an SPI master. It also produces one launch pulse and one sample pulse for each bit, so that the shift engine beside it knows when to drive data and when to capture it. Two divider families are available. The power-of-two path gives ratios of 4, 8, 16 and so on, up to 512, using a 3-bit exponent. The fine path gives any even ratio from 2 to 512, using an 8-bit count. A path-select input chooses between the two families.

The shift engine raises `run_i` for the length of a burst. While `run_i` is low, the serial clock rests at the level set by clock polarity, the divider counter is held at zero, and the block takes in the divider fields, the path select, polarity and phase. While `run_i` is high, those captured settings are frozen. A burst therefore never sees a changed ratio or a runt pulse, and the first serial-clock edge always falls one full half period after the start.

Top module: `sclk_dual_div`

## Requirements
- R1: With `path_sel_i` = 0, each half period of `sclk_o` lasts 2^(E+1) source cycles, where E is `pow2_exp_i`. The full ratio is therefore 2^(E+2).
- R2: With `path_sel_i` = 1, each half period lasts F+1 source cycles, where F is `fine_div_i`, for a full ratio of 2*(F+1). With F = 0, `sclk_o` toggles on every source cycle, which is divide-by-2 at 50% duty.
- R3: `path_sel_i` = 1 selects the fine path and 0 selects the power-of-two path. The field of the unselected path has no effect on timing.
- R4: While reset is held, `sclk_o`, `launch_o` and `sample_o` are 0. After the first clock edge with reset released and `run_i` low, `sclk_o` equals `cpol_i`.
- R5: Count the first clock edge that samples `run_i` high as edge 1. The first `sclk_o` transition happens at edge H, where H is the half period in source cycles. Dropping `run_i` for one cycle restarts this count.
- R6: `launch_o` and `sample_o` are single-cycle pulses that rise in the same cycle as an `sclk_o` transition. They are never high together, and neither is high in a cycle without a transition.
- R7: The leading edge is a transition away from the idle level, and the trailing edge is a transition back to it. With `cpha_i` = 0, `sample_o` pulses on leading edges and `launch_o` on trailing edges. With `cpha_i` = 1, the roles are swapped.
- R8: The divider fields, path select, `cpol_i` and `cpha_i` are captured only on edges where `run_i` is low. Changing them while `run_i` is high leaves the half period and the strobe roles unchanged until the next idle interval.
- R9: One clock edge after `run_i` is sampled low, `sclk_o` is back at the idle level and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pow2_exp_i | input | 3 | Exponent E of the power-of-two path |
| fine_div_i | input | 8 | Count F of the fine path |
| path_sel_i | input | 1 | 1 = fine path, 0 = power-of-two path |
| cpol_i | input | 1 | Serial-clock idle level |
| cpha_i | input | 1 | Phase: 0 = sample on leading edge, 1 = launch on leading edge |
| run_i | input | 1 | Burst active, driven by the shift engine |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | Drive-data strobe, one source cycle |
| sample_o | output | 1 | Capture-data strobe, one source cycle |

## Verification
The hardest situation to reach from the ports is a settings change that lands in the middle of a running burst. The bench creates it by switching the path, both divider fields, polarity and phase right after the first serial-clock edge of a divide-by-2 burst. It then checks that the next transition still arrives one cycle later, with the old strobe roles. A second hard case is a restart partway through a half period. The stimulus drops `run_i` for a single cycle in the middle of a 16-cycle half period and checks that the first edge then takes a full 16 cycles again. The table sweep covers both extremes of each path, including the fine path at F = 0, where a strobe fires on every cycle.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

   // Path encoding seen on path_sel_i
   typedef enum logic {
      PATH_POW2 = 1'b0,
      PATH_FINE = 1'b1
   } path_e;

   // Width needed to hold (half period - 1) for both paths
   function automatic int half_width(input int pow2_w, input int fine_w);
      int p;
      p = 1 << pow2_w;
      return (p > fine_w) ? p : fine_w;
   endfunction

endpackage

// File: rtl/sclk_div_cfg.sv
// Shadow copy of the divider settings. It loads only while the burst is idle
// and turns the selected path into a terminal count (half period - 1).
module sclk_div_cfg
   import sclk_div_pkg::*;
#(
   parameter int POW2_W  = 3,
   parameter int FINE_W  = 8,
   parameter bit HAS_FINE = 1'b1,
   parameter int HALF_W  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic [POW2_W-1:0] pow2_exp_i,
   input  logic [FINE_W-1:0] fine_div_i,
   input  logic              path_sel_i,
   input  logic              cpol_i,
   input  logic              cpha_i,
   output logic [HALF_W-1:0] term_o,
   output logic              cpol_o,
   output logic              cpha_o
);

   logic [POW2_W-1:0] exp_q;
   logic [FINE_W-1:0] fine_q;
   path_e             sel_q;
   logic              cpol_q;
   logic              cpha_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         exp_q  <= '0;
         fine_q <= '0;
         sel_q  <= PATH_POW2;
         cpol_q <= 1'b0;
         cpha_q <= 1'b0;
      end else if (!run_i) begin
         exp_q  <= pow2_exp_i;
         fine_q <= fine_div_i;
         sel_q  <= path_e'(path_sel_i);
         cpol_q <= cpol_i;
         cpha_q <= cpha_i;
      end
   end

   // Power-of-two half period is 2^(E+1). At the largest E the shifted one
   // leaves the vector and the subtraction wraps to all ones, which is the
   // wanted terminal count.
   logic [POW2_W:0]   shamt;
   logic [HALF_W-1:0] pow2_term;

   always_comb begin
      shamt     = {1'b0, exp_q} + (POW2_W+1)'(1);
      pow2_term = (HALF_W'(1) << shamt) - HALF_W'(1);
   end

   generate
      if (HAS_FINE) begin : g_two_path
         always_comb begin
            if (sel_q == PATH_FINE) term_o = HALF_W'(fine_q);
            else                    term_o = pow2_term;
         end
      end else begin : g_pow2_only
         always_comb term_o = pow2_term;
      end
   endgenerate

   assign cpol_o = cpol_q;
   assign cpha_o = cpha_q;

endmodule

// File: rtl/sclk_div_count.sv
// Half-period counter. It is held at zero while idle and wraps at the terminal count.
module sclk_div_count #(
   parameter int HALF_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic [HALF_W-1:0] term_i,
   output logic              tick_o
);

   logic [HALF_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == term_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cnt_q <= '0;
      else if (!run_i || tick_o)   cnt_q <= '0;
      else                         cnt_q <= cnt_q + HALF_W'(1);
   end

endmodule

// File: rtl/sclk_div_edge.sv
// Serial-clock flop and per-edge strobes with phase applied.
module sclk_div_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic tick_i,
   input  logic idle_lvl_i,
   input  logic cpol_q_i,
   input  logic cpha_q_i,
   output logic sclk_o,
   output logic launch_o,
   output logic sample_o
);

   logic sclk_q, launch_q, sample_q;
   logic leading;
   logic samp_now;

   always_comb begin
      leading  = (sclk_q == cpol_q_i);
      samp_now = leading ^ cpha_q_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sclk_q   <= 1'b0;
         launch_q <= 1'b0;
         sample_q <= 1'b0;
      end else if (!run_i) begin
         sclk_q   <= idle_lvl_i;
         launch_q <= 1'b0;
         sample_q <= 1'b0;
      end else if (tick_i) begin
         sclk_q   <= ~sclk_q;
         sample_q <= samp_now;
         launch_q <= ~samp_now;
      end else begin
         launch_q <= 1'b0;
         sample_q <= 1'b0;
      end
   end

   assign sclk_o   = sclk_q;
   assign launch_o = launch_q;
   assign sample_o = sample_q;

endmodule

// File: rtl/sclk_dual_div.sv
module sclk_dual_div
   import sclk_div_pkg::*;
#(
   parameter int POW2_W   = 3,
   parameter int FINE_W   = 8,
   parameter bit HAS_FINE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [POW2_W-1:0] pow2_exp_i,
   input  logic [FINE_W-1:0] fine_div_i,
   input  logic              path_sel_i,
   input  logic              cpol_i,
   input  logic              cpha_i,
   input  logic              run_i,
   output logic              sclk_o,
   output logic              launch_o,
   output logic              sample_o
);

   localparam int HALF_W = half_width(POW2_W, FINE_W);

   generate
      if (POW2_W < 1 || POW2_W > 4) begin : g_bad_pow2
         $error("sclk_dual_div: POW2_W must lie in 1..4");
      end
      if (FINE_W < 1 || FINE_W > 16) begin : g_bad_fine
         $error("sclk_dual_div: FINE_W must lie in 1..16");
      end
   endgenerate

   logic [HALF_W-1:0] term;
   logic              cpol_q, cpha_q, tick;

   sclk_div_cfg #(
      .POW2_W  (POW2_W),
      .FINE_W  (FINE_W),
      .HAS_FINE(HAS_FINE),
      .HALF_W  (HALF_W)
   ) u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_i),
      .pow2_exp_i (pow2_exp_i),
      .fine_div_i (fine_div_i),
      .path_sel_i (path_sel_i),
      .cpol_i     (cpol_i),
      .cpha_i     (cpha_i),
      .term_o     (term),
      .cpol_o     (cpol_q),
      .cpha_o     (cpha_q)
   );

   sclk_div_count #(.HALF_W(HALF_W)) u_count (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_i),
      .term_i (term),
      .tick_o (tick)
   );

   sclk_div_edge u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_i),
      .tick_i     (tick),
      .idle_lvl_i (cpol_i),
      .cpol_q_i   (cpol_q),
      .cpha_q_i   (cpha_q),
      .sclk_o     (sclk_o),
      .launch_o   (launch_o),
      .sample_o   (sample_o)
   );

endmodule

// File: rtl/sclk_dual_div_chk.sv
module sclk_dual_div_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic cpol_i,
   input logic run_i,
   input logic sclk_o,
   input logic launch_o,
   input logic sample_o
);

   // R4
   idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (sclk_o == $past(cpol_i)));

   // R9
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (!launch_o && !sample_o));

   // R6
   strobe_mutex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(launch_o && sample_o));

   // R6
   strobe_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (launch_o || sample_o) |-> (sclk_o != $past(sclk_o)));

   // R7
   edge_has_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(run_i) && (sclk_o != $past(sclk_o))) |-> (launch_o || sample_o));

   // R6
   launch_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      launch_o |=> !launch_o);

   // R6
   sample_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_o |=> !sample_o);

endmodule

bind sclk_dual_div sclk_dual_div_chk u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .cpol_i   (cpol_i),
   .run_i    (run_i),
   .sclk_o   (sclk_o),
   .launch_o (launch_o),
   .sample_o (sample_o)
);

// File: tb/sclk_dual_div_bench.sv
module sclk_dual_div_bench;

   localparam time CLK_P = 20ns;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic [2:0] pow2_exp_i = '0;
   logic [7:0] fine_div_i = '0;
   logic       path_sel_i = 1'b0;
   logic       cpol_i = 1'b0;
   logic       cpha_i = 1'b0;
   logic       run_i = 1'b0;
   logic       sclk_o, launch_o, sample_o;

   always #(CLK_P/2) clk_i = ~clk_i;

   sclk_dual_div u_sclk_dual_div (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pow2_exp_i (pow2_exp_i),
      .fine_div_i (fine_div_i),
      .path_sel_i (path_sel_i),
      .cpol_i     (cpol_i),
      .cpha_i     (cpha_i),
      .run_i      (run_i),
      .sclk_o     (sclk_o),
      .launch_o   (launch_o),
      .sample_o   (sample_o)
   );

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // {sel, exp[2:0], fine[7:0], cpol, cpha, half[9:0]} = 24 bits
   localparam int NV = 9;
   localparam logic [23:0] VECS [NV] = '{
      {1'b0, 3'd0, 8'd0,   1'b0, 1'b0, 10'd2},
      {1'b0, 3'd3, 8'd0,   1'b1, 1'b1, 10'd16},
      {1'b0, 3'd7, 8'd0,   1'b0, 1'b1, 10'd256},
      {1'b1, 3'd0, 8'd0,   1'b0, 1'b0, 10'd1},
      {1'b1, 3'd5, 8'd0,   1'b1, 1'b1, 10'd1},
      {1'b1, 3'd0, 8'd4,   1'b1, 1'b0, 10'd5},
      {1'b1, 3'd0, 8'd255, 1'b0, 1'b0, 10'd256},
      {1'b0, 3'd1, 8'd9,   1'b0, 1'b1, 10'd4},
      {1'b1, 3'd7, 8'd2,   1'b1, 1'b0, 10'd3}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Counts negedges until sclk_o changes; stray strobes seen meanwhile are counted
   task automatic wait_toggle(output int n, output int stray);
      logic prev;
      prev  = sclk_o;
      n     = 0;
      stray = 0;
      do begin
         @(negedge clk_i);
         n++;
         if (sclk_o == prev && (launch_o || sample_o)) stray++;
      end while (sclk_o == prev && n < 1000);
   endtask

   task automatic idle(input int cycles);
      @(negedge clk_i);
      run_i = 1'b0;
      repeat (cycles) @(negedge clk_i);
   endtask

   initial begin
      #(CLK_P * 200000);
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      n_fail++;
      n_run++;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int n, stray;
      // Reset state (R4)
      cpol_i = 1'b1;
      repeat (3) @(negedge clk_i);
      chk(sclk_o == 1'b0 && !launch_o && !sample_o, "R4 reset outputs",
          {sclk_o, launch_o, sample_o}, 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      chk(sclk_o == 1'b1, "R4 idle level after reset", sclk_o, 1);

      // Table sweep (R1 R2 R3 R5 R6 R7 R9)
      for (int i = 0; i < NV; i++) begin
         logic [23:0] v;
         int half;
         v = VECS[i];
         path_sel_i = v[23];
         pow2_exp_i = v[22:20];
         fine_div_i = v[19:12];
         cpol_i     = v[11];
         cpha_i     = v[10];
         half       = int'(v[9:0]);
         repeat (3) @(negedge clk_i);
         chk(sclk_o == cpol_i, "R4 idle level", sclk_o, cpol_i);
         run_i = 1'b1;
         wait_toggle(n, stray);
         chk(n == half, v[23] ? "R2/R5 first half period" : "R1/R5 first half period", n, half);
         chk(sample_o == !cpha_i && launch_o == cpha_i, "R7 leading strobe role",
             {launch_o, sample_o}, {cpha_i, !cpha_i});
         wait_toggle(n, stray);
         chk(n == half, v[23] ? "R2/R3 second half period" : "R1/R3 second half period", n, half);
         chk(sample_o == cpha_i && launch_o == !cpha_i, "R7 trailing strobe role",
             {launch_o, sample_o}, {!cpha_i, cpha_i});
         chk(stray == 0, "R6 no strobe between edges", stray, 0);
         run_i = 1'b0;
         @(negedge clk_i);
         chk(sclk_o == cpol_i && !launch_o && !sample_o, "R9 return to idle",
             {sclk_o, launch_o, sample_o}, {cpol_i, 2'b00});
      end

      // Settings changed mid-burst are ignored (R8)
      idle(2);
      path_sel_i = 1'b1; fine_div_i = 8'd0; cpol_i = 1'b0; cpha_i = 1'b0;
      repeat (2) @(negedge clk_i);
      run_i = 1'b1;
      wait_toggle(n, stray);
      chk(n == 1, "R8 base half period", n, 1);
      path_sel_i = 1'b0; pow2_exp_i = 3'd7; fine_div_i = 8'd5; cpol_i = 1'b1; cpha_i = 1'b1;
      wait_toggle(n, stray);
      chk(n == 1, "R8 half period held during burst", n, 1);
      chk(sample_o == 1'b0 && launch_o == 1'b1, "R8 strobe role held during burst",
          {launch_o, sample_o}, 2'b10);
      idle(2);
      chk(sclk_o == 1'b1, "R8 new idle level taken while idle", sclk_o, 1);
      run_i = 1'b1;
      wait_toggle(n, stray);
      chk(n == 256, "R8 new ratio taken while idle", n, 256);
      chk(launch_o == 1'b1 && sample_o == 1'b0, "R8 new phase taken while idle",
          {launch_o, sample_o}, 2'b10);

      // Restart partway through a half period (R5)
      idle(2);
      path_sel_i = 1'b0; pow2_exp_i = 3'd3; cpol_i = 1'b0; cpha_i = 1'b0;
      repeat (2) @(negedge clk_i);
      run_i = 1'b1;
      repeat (5) @(negedge clk_i);
      chk(sclk_o == 1'b0, "R5 no edge before half period", sclk_o, 0);
      run_i = 1'b0;
      @(negedge clk_i);
      run_i = 1'b1;
      wait_toggle(n, stray);
      chk(n == 16, "R5 restart gives full half period", n, 16);
      idle(2);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule